// File: doc/BRIEF.md
# MAC address table command engine

This block keeps a small forwarding table. Each entry is keyed by a 12-bit VLAN ID together with a 48-bit MAC address. Software drives it through a few register-style words: two key words, an attribute word, a scan setting, an ageing setting, and a control word made of a command code, an entry index and a start ("shot") bit. When software writes the control word with shot set, the engine runs the command over its entry storage. Results come back in the same key and attribute words. The shot bit stays at 1 until the command has finished, so software polls it to learn when the result is ready.

The commands are learn, unlearn, lookup, read and write at an index, a single ageing sweep, find-next-smallest, and clear-all. The find-next-smallest command orders keys with the VLAN ID as the most significant part. It lets software walk the whole table in ascending order by feeding each result back as the next starting key.

A background timer can trigger one-bit ageing sweeps. Each sweep marks the idle unlocked entries and removes those that were already marked, so an entry with no traffic disappears after two sweeps. The table depth is a parameter and is meant to be 16 or 32 entries. Clear-all and ageing sweeps visit one entry per clock.

Top module: `mac_table_engine`

## Requirements
- R1: After reset the shot bit and the full flag read 0, both key words and the attribute word read 0, the table holds no valid entry, and ageing is disabled.
- R2: Writing the control word with the shot bit at 1 while shot reads 0 starts the command given by the 3-bit code (0 learn, 1 unlearn, 2 lookup, 3 read at index, 4 write at index, 5 ageing sweep, 6 find next smallest, 7 clear all). Shot reads 1 until the command completes and then returns to 0. While shot reads 1, writes to the control, key, attribute and scan words are ignored.
- R3: Key word 0 carries the VLAN ID in bits [27:16] (bits [31:28] read 0) and MAC bytes 0 and 1 in bits [15:8] and [7:0]. Key word 1 carries MAC bytes 2 to 5, from bit 31 down to bit 0. Both words read back exactly as they were written.
- R4: The attribute word carries the destination in bits [11:0], a 2-bit type in bits [13:12] (0 port, 1 CPU/internal, 2 aggregation group, 3 multicast index), valid in bit 16 and locked in bit 17. A learn stores the destination, type and locked fields under the loaded key. A later lookup of that key returns those fields with bit 16 set.
- R5: A lookup whose key matches no valid entry makes the attribute word read 0.
- R6: A learn on a key that is already stored overwrites that entry's attributes. It never creates a second entry with the same key.
- R7: A learn of a new key when every entry is valid leaves the table unchanged and sets a full flag. The flag stays at 1 until a clear-all.
- R8: An unlearn removes the entry whose key matches the loaded key, so a later lookup of that key misses.
- R9: A read at index loads the key words and the attribute word (valid included) from that entry. A write at index stores the loaded key and attribute word into that entry. The write is dropped if the key is valid at a different index.
- R10: Find-next-smallest returns the valid entry with the smallest {VLAN, MAC} key strictly greater than the loaded key. It writes that key into the key words and the entry's attributes into the attribute word. If no such entry exists, the attribute word reads 0 and the key words are left unchanged.
- R11: When the scan setting's skip-locked enable is 1, find-next-smallest passes over entries whose locked bit is set.
- R12: Clear-all visits the entries one per clock, keeps shot at 1 for at least as many cycles as there are entries, and leaves no valid entry.
- R13: Each ageing sweep invalidates every unlocked valid entry whose age mark is already set and marks every other unlocked valid entry. Locked entries are never removed. A learn or lookup hit clears the entry's age mark.
- R14: The ageing setting holds a 2-bit unit code and a period count. The unit code gives a unit of BASE_CYCLES times 1, 10, 100 or 1000 clocks. A background sweep runs every period-count units, and a period of 0 disables the background sweeps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key0_we | input | 1 | Write strobe for key word 0 |
| key0_wdata | input | 32 | VLAN ID and MAC bytes 0-1 |
| key1_we | input | 1 | Write strobe for key word 1 |
| key1_wdata | input | 32 | MAC bytes 2-5 |
| attr_we | input | 1 | Write strobe for the attribute word |
| attr_wdata | input | 32 | Destination, type, valid, locked |
| ctrl_we | input | 1 | Write strobe for the control word |
| ctrl_cmd | input | 3 | Command code |
| ctrl_shot | input | 1 | Start bit |
| ctrl_index | input | $clog2(ENTRIES) | Entry index for read/write at index |
| scan_we | input | 1 | Write strobe for the scan setting |
| scan_skip_locked | input | 1 | Skip locked entries in find-next |
| age_we | input | 1 | Write strobe for the ageing setting |
| age_unit | input | 2 | Ageing unit code |
| age_period | input | PER_W | Ageing period in units, 0 disables |
| key0_rd | output | 32 | Key word 0 read-back |
| key1_rd | output | 32 | Key word 1 read-back |
| attr_rd | output | 32 | Attribute word read-back |
| shot_rd | output | 1 | Shot bit, 1 while a command is in progress |
| full_rd | output | 1 | Sticky table-full flag |

## Verification
The bench builds the block with ENTRIES = 16, BASE_CYCLES = 2 and PER_W = 10. At that size the table can be filled completely, so the full path is reachable. The find-next command can also walk every one of the 16 stored keys, with and without skipping the locked ones, and each step is compared against an ascending order that the bench computes itself. A base unit of two clocks makes a background sweep take only tens of cycles, so timed ageing, a disabled timer and the slow 1000x unit code can all be observed within a short run.

// File: rtl/mact_pkg.sv
package mact_pkg;

    localparam int VID_W = 12;
    localparam int MAC_W = 48;
    localparam int KEY_W = VID_W + MAC_W;
    localparam int DST_W = 12;

    typedef enum logic [2:0] {
        CMD_LEARN   = 3'd0,
        CMD_UNLEARN = 3'd1,
        CMD_LOOKUP  = 3'd2,
        CMD_READ    = 3'd3,
        CMD_WRITE   = 3'd4,
        CMD_AGE     = 3'd5,
        CMD_NEXT    = 3'd6,
        CMD_CLEAR   = 3'd7
    } mact_cmd_e;

    typedef enum logic [1:0] {
        DST_PORT  = 2'd0,
        DST_CPU   = 2'd1,
        DST_AGGR  = 2'd2,
        DST_MCAST = 2'd3
    } dst_kind_e;

    typedef struct packed {
        logic              locked;
        logic              valid;
        dst_kind_e         kind;
        logic [DST_W-1:0]  dst;
    } attr_t;

    typedef struct packed {
        attr_t             attr;
        logic              aged;
        logic [KEY_W-1:0]  key;   // {vid, mac}: VLAN is the major part of the order
    } entry_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EXEC  = 2'd1,
        ST_CLEAR = 2'd2,
        ST_AGE   = 2'd3
    } eng_state_e;

endpackage

// File: rtl/mact_search.sv
module mact_search #(
    parameter int N     = 16,
    parameter int KEY_W = 60
) (
    input  logic [N-1:0][KEY_W-1:0] keys,
    input  logic [N-1:0]            valid,
    input  logic [N-1:0]            locked,
    input  logic [KEY_W-1:0]        probe,
    input  logic                    skip_locked,
    output logic [N-1:0]            match,
    output logic                    hit,
    output logic [$clog2(N)-1:0]    hit_idx,
    output logic                    has_free,
    output logic [$clog2(N)-1:0]    free_idx,
    output logic                    has_next,
    output logic [$clog2(N)-1:0]    next_idx
);
    localparam int IDX_W = $clog2(N);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = valid[g] && (keys[g] == probe);
    end

    // exact match and first free slot, lowest index wins
    always_comb begin
        hit      = 1'b0;
        hit_idx  = '0;
        has_free = 1'b0;
        free_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i] && !hit) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
            if (!valid[i] && !has_free) begin
                has_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    // smallest key strictly above the probe
    logic [KEY_W-1:0] best;
    always_comb begin
        has_next = 1'b0;
        next_idx = '0;
        best     = '0;
        for (int i = 0; i < N; i++) begin
            if (valid[i] && !(skip_locked && locked[i]) && (keys[i] > probe) &&
                (!has_next || (keys[i] < best))) begin
                has_next = 1'b1;
                next_idx = IDX_W'(i);
                best     = keys[i];
            end
        end
    end

endmodule

// File: rtl/mact_age_timer.sv
module mact_age_timer #(
    parameter int BASE_CYCLES = 2,
    parameter int PER_W       = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_unit,
    input  logic [PER_W-1:0] cfg_period,
    output logic             tick
);
    localparam int UNIT_MAX = BASE_CYCLES * 1000;
    localparam int CNT_W    = $clog2(UNIT_MAX + 1);

    typedef struct packed {
        logic [1:0]       code;
        logic [PER_W-1:0] period;
        logic [CNT_W-1:0] ucnt;
        logic [PER_W-1:0] pcnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    function automatic logic [CNT_W-1:0] unit_len(input logic [1:0] c);
        case (c)
            2'd0:    return CNT_W'(BASE_CYCLES);
            2'd1:    return CNT_W'(BASE_CYCLES * 10);
            2'd2:    return CNT_W'(BASE_CYCLES * 100);
            default: return CNT_W'(BASE_CYCLES * 1000);
        endcase
    endfunction

    always_comb begin
        tmr_d = tmr_q;
        tick  = 1'b0;
        if (cfg_we) begin
            tmr_d.code   = cfg_unit;
            tmr_d.period = cfg_period;
            tmr_d.ucnt   = '0;
            tmr_d.pcnt   = '0;
        end else if (tmr_q.period != '0) begin
            if (tmr_q.ucnt == unit_len(tmr_q.code) - 1'b1) begin
                tmr_d.ucnt = '0;
                if (tmr_q.pcnt == tmr_q.period - 1'b1) begin
                    tmr_d.pcnt = '0;
                    tick       = 1'b1;
                end else begin
                    tmr_d.pcnt = tmr_q.pcnt + 1'b1;
                end
            end else begin
                tmr_d.ucnt = tmr_q.ucnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

endmodule

// File: rtl/mac_table_engine.sv
module mac_table_engine #(
    parameter int ENTRIES     = 16,
    parameter int BASE_CYCLES = 2,
    parameter int PER_W       = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       key0_we,
    input  logic [31:0]                key0_wdata,
    input  logic                       key1_we,
    input  logic [31:0]                key1_wdata,
    input  logic                       attr_we,
    input  logic [31:0]                attr_wdata,
    input  logic                       ctrl_we,
    input  logic [2:0]                 ctrl_cmd,
    input  logic                       ctrl_shot,
    input  logic [$clog2(ENTRIES)-1:0] ctrl_index,
    input  logic                       scan_we,
    input  logic                       scan_skip_locked,
    input  logic                       age_we,
    input  logic [1:0]                 age_unit,
    input  logic [PER_W-1:0]           age_period,
    output logic [31:0]                key0_rd,
    output logic [31:0]                key1_rd,
    output logic [31:0]                attr_rd,
    output logic                       shot_rd,
    output logic                       full_rd
);
    import mact_pkg::*;

    localparam int IDX_W = $clog2(ENTRIES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        eng_state_e              state;
        logic                    shot;
        mact_cmd_e               cmd;
        logic [IDX_W-1:0]        idx;
        logic                    sweep_cmd;
        logic [IDX_W-1:0]        ptr;
        logic                    full;
        logic                    skip_locked;
        logic                    age_req;
        logic [KEY_W-1:0]        key;
        attr_t                   attr;
        entry_t [ENTRIES-1:0]    ent;
    } eng_t;

    eng_t eng_d, eng_q;

    // ---------------- search over stored entries ----------------
    logic [ENTRIES-1:0][KEY_W-1:0] key_arr;
    logic [ENTRIES-1:0]            valid_vec;
    logic [ENTRIES-1:0]            lock_vec;
    logic [ENTRIES-1:0]            match_vec;
    logic                          hit, has_free, has_next;
    logic [IDX_W-1:0]              hit_idx, free_idx, next_idx;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            key_arr[i]   = eng_q.ent[i].key;
            valid_vec[i] = eng_q.ent[i].attr.valid;
            lock_vec[i]  = eng_q.ent[i].attr.locked;
        end
    end

    mact_search #(
        .N     (ENTRIES),
        .KEY_W (KEY_W)
    ) u_search (
        .keys        (key_arr),
        .valid       (valid_vec),
        .locked      (lock_vec),
        .probe       (eng_q.key),
        .skip_locked (eng_q.skip_locked),
        .match       (match_vec),
        .hit         (hit),
        .hit_idx     (hit_idx),
        .has_free    (has_free),
        .free_idx    (free_idx),
        .has_next    (has_next),
        .next_idx    (next_idx)
    );

    // ---------------- ageing timer ----------------
    logic age_tick;

    mact_age_timer #(
        .BASE_CYCLES (BASE_CYCLES),
        .PER_W       (PER_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (age_we),
        .cfg_unit   (age_unit),
        .cfg_period (age_period),
        .tick       (age_tick)
    );

    function automatic attr_t attr_unpack(input logic [31:0] w);
        attr_t a;
        a.locked = w[17];
        a.valid  = w[16];
        a.kind   = dst_kind_e'(w[13:12]);
        a.dst    = w[DST_W-1:0];
        return a;
    endfunction

    function automatic attr_t attr_keep(input attr_t a);
        attr_t r;
        r       = a;
        r.valid = 1'b1;
        return r;
    endfunction

    // ---------------- next state ----------------
    always_comb begin
        eng_d = eng_q;

        // software-side writes, only while no command is pending
        if (!eng_q.shot) begin
            if (key0_we) begin
                eng_d.key[KEY_W-1 -: VID_W] = key0_wdata[16 +: VID_W];
                eng_d.key[MAC_W-1 -: 16]    = key0_wdata[15:0];
            end
            if (key1_we) eng_d.key[31:0] = key1_wdata;
            if (attr_we) eng_d.attr = attr_unpack(attr_wdata);
            if (scan_we) eng_d.skip_locked = scan_skip_locked;
            if (ctrl_we && ctrl_shot) begin
                eng_d.shot = 1'b1;
                eng_d.cmd  = mact_cmd_e'(ctrl_cmd);
                eng_d.idx  = ctrl_index;
            end
        end

        unique case (eng_q.state)
            ST_IDLE: begin
                if (eng_q.shot) begin
                    if (eng_q.cmd == CMD_CLEAR) begin
                        eng_d.state = ST_CLEAR;
                        eng_d.ptr   = '0;
                        eng_d.full  = 1'b0;
                    end else if (eng_q.cmd == CMD_AGE) begin
                        eng_d.state     = ST_AGE;
                        eng_d.ptr       = '0;
                        eng_d.sweep_cmd = 1'b1;
                    end else begin
                        eng_d.state = ST_EXEC;
                    end
                end else if (eng_q.age_req) begin
                    eng_d.state     = ST_AGE;
                    eng_d.ptr       = '0;
                    eng_d.sweep_cmd = 1'b0;
                    eng_d.age_req   = 1'b0;
                end
            end

            ST_EXEC: begin
                eng_d.state = ST_IDLE;
                eng_d.shot  = 1'b0;
                case (eng_q.cmd)
                    CMD_LEARN: begin
                        if (hit) begin
                            eng_d.ent[hit_idx].attr = attr_keep(eng_q.attr);
                            eng_d.ent[hit_idx].aged = 1'b0;
                        end else if (has_free) begin
                            eng_d.ent[free_idx].key  = eng_q.key;
                            eng_d.ent[free_idx].attr = attr_keep(eng_q.attr);
                            eng_d.ent[free_idx].aged = 1'b0;
                        end else begin
                            eng_d.full = 1'b1;
                        end
                    end
                    CMD_UNLEARN: begin
                        if (hit) begin
                            eng_d.ent[hit_idx].attr.valid = 1'b0;
                            eng_d.ent[hit_idx].aged       = 1'b0;
                        end
                    end
                    CMD_LOOKUP: begin
                        if (hit) begin
                            eng_d.attr              = eng_q.ent[hit_idx].attr;
                            eng_d.ent[hit_idx].aged = 1'b0;
                        end else begin
                            eng_d.attr = '0;
                        end
                    end
                    CMD_READ: begin
                        eng_d.key  = eng_q.ent[eng_q.idx].key;
                        eng_d.attr = eng_q.ent[eng_q.idx].attr;
                    end
                    CMD_WRITE: begin
                        if (!(hit && (hit_idx != eng_q.idx))) begin
                            eng_d.ent[eng_q.idx].key  = eng_q.key;
                            eng_d.ent[eng_q.idx].attr = eng_q.attr;
                            eng_d.ent[eng_q.idx].aged = 1'b0;
                        end
                    end
                    CMD_NEXT: begin
                        if (has_next) begin
                            eng_d.key  = eng_q.ent[next_idx].key;
                            eng_d.attr = eng_q.ent[next_idx].attr;
                        end else begin
                            eng_d.attr = '0;
                        end
                    end
                    default: ;
                endcase
            end

            ST_CLEAR: begin
                eng_d.ent[eng_q.ptr].attr.valid = 1'b0;
                eng_d.ent[eng_q.ptr].aged       = 1'b0;
                if (eng_q.ptr == LAST_IDX) begin
                    eng_d.state = ST_IDLE;
                    eng_d.shot  = 1'b0;
                end else begin
                    eng_d.ptr = eng_q.ptr + 1'b1;
                end
            end

            ST_AGE: begin
                if (eng_q.ent[eng_q.ptr].attr.valid && !eng_q.ent[eng_q.ptr].attr.locked) begin
                    if (eng_q.ent[eng_q.ptr].aged) begin
                        eng_d.ent[eng_q.ptr].attr.valid = 1'b0;
                        eng_d.ent[eng_q.ptr].aged       = 1'b0;
                    end else begin
                        eng_d.ent[eng_q.ptr].aged = 1'b1;
                    end
                end
                if (eng_q.ptr == LAST_IDX) begin
                    eng_d.state     = ST_IDLE;
                    eng_d.sweep_cmd = 1'b0;
                    if (eng_q.sweep_cmd) eng_d.shot = 1'b0;
                end else begin
                    eng_d.ptr = eng_q.ptr + 1'b1;
                end
            end

            default: eng_d.state = ST_IDLE;
        endcase

        if (age_tick) eng_d.age_req = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    // ---------------- read-back ----------------
    assign key0_rd = {4'b0, eng_q.key[KEY_W-1 -: VID_W], eng_q.key[MAC_W-1 -: 16]};
    assign key1_rd = eng_q.key[31:0];
    assign attr_rd = {14'b0, eng_q.attr.locked, eng_q.attr.valid, 2'b0,
                      eng_q.attr.kind, eng_q.attr.dst};
    assign shot_rd = eng_q.shot;
    assign full_rd = eng_q.full;

    // status taps for the bound checker
    logic sweep_on, clear_on, clear_start;
    assign sweep_on    = (eng_q.state == ST_AGE);
    assign clear_on    = (eng_q.state == ST_CLEAR);
    assign clear_start = (eng_q.state == ST_IDLE) && eng_q.shot && (eng_q.cmd == CMD_CLEAR);

    logic unused_bits;
    assign unused_bits = ^{key0_wdata[31:28], attr_wdata[31:18], attr_wdata[15:14]};

endmodule

// File: rtl/mact_checker.sv
module mact_checker #(
    parameter int ENTRIES = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ctrl_we,
    input logic               ctrl_shot,
    input logic               key1_we,
    input logic [31:0]        key1_rd,
    input logic               shot_rd,
    input logic               full_rd,
    input logic [ENTRIES-1:0] valid_vec,
    input logic [ENTRIES-1:0] lock_vec,
    input logic [ENTRIES-1:0] match_vec,
    input logic               sweep_on,
    input logic               clear_on,
    input logic               clear_start
);

    p_shot_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shot_rd) |-> $past(ctrl_we && ctrl_shot));

    p_key_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (key1_rd != $past(key1_rd)) |-> ($past(key1_we && !shot_rd) || $fell(shot_rd)));

    p_unique_key_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(match_vec) <= 1);

    p_full_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (full_rd && !clear_start) |=> full_rd);

    p_clear_empty_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(shot_rd) && $past(clear_on)) |-> (valid_vec == '0));

    for (genvar g = 0; g < ENTRIES; g++) begin : g_lock
        p_locked_kept_r13: assert property (@(posedge clk) disable iff (!rst_n)
            (sweep_on && valid_vec[g] && lock_vec[g]) |=> valid_vec[g]);
    end

endmodule

bind mac_table_engine mact_checker #(.ENTRIES(ENTRIES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_we     (ctrl_we),
    .ctrl_shot   (ctrl_shot),
    .key1_we     (key1_we),
    .key1_rd     (key1_rd),
    .shot_rd     (shot_rd),
    .full_rd     (full_rd),
    .valid_vec   (valid_vec),
    .lock_vec    (lock_vec),
    .match_vec   (match_vec),
    .sweep_on    (sweep_on),
    .clear_on    (clear_on),
    .clear_start (clear_start)
);

// File: tb/mac_table_engine_test.sv
module mac_table_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int ENTRIES    = 16;
    localparam int IDX_W      = $clog2(ENTRIES);
    localparam int PER_W      = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic key0_we = 0, key1_we = 0, attr_we = 0, ctrl_we = 0, ctrl_shot = 0;
    logic scan_we = 0, scan_skip_locked = 0, age_we = 0;
    logic [31:0] key0_wdata = 0, key1_wdata = 0, attr_wdata = 0;
    logic [2:0]  ctrl_cmd = 0;
    logic [IDX_W-1:0] ctrl_index = 0;
    logic [1:0]  age_unit = 0;
    logic [PER_W-1:0] age_period = 0;
    logic [31:0] key0_rd, key1_rd, attr_rd;
    logic shot_rd, full_rd;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [59:0] mkey [ENTRIES];
    bit          mval [ENTRIES];
    bit          mlock[ENTRIES];

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_table_engine #(
        .ENTRIES(ENTRIES), .BASE_CYCLES(2), .PER_W(PER_W)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .key0_we(key0_we), .key0_wdata(key0_wdata),
        .key1_we(key1_we), .key1_wdata(key1_wdata),
        .attr_we(attr_we), .attr_wdata(attr_wdata),
        .ctrl_we(ctrl_we), .ctrl_cmd(ctrl_cmd), .ctrl_shot(ctrl_shot), .ctrl_index(ctrl_index),
        .scan_we(scan_we), .scan_skip_locked(scan_skip_locked),
        .age_we(age_we), .age_unit(age_unit), .age_period(age_period),
        .key0_rd(key0_rd), .key1_rd(key1_rd), .attr_rd(attr_rd),
        .shot_rd(shot_rd), .full_rd(full_rd)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [59:0] mk(input int i);
        logic [11:0] v;
        logic [47:0] m;
        v = 12'(1 + (i * 5) % 3);
        m = 48'h0200_0000_1000 + 48'((i * 13) % 16);
        return {v, m};
    endfunction

    function automatic logic [59:0] got_key();
        return {key0_rd[27:0], key1_rd};
    endfunction

    function automatic int exp_next(input logic [59:0] cur, input bit skip);
        int best;
        best = -1;
        for (int i = 0; i < ENTRIES; i++)
            if (mval[i] && !(skip && mlock[i]) && mkey[i] > cur &&
                (best < 0 || mkey[i] < mkey[best])) best = i;
        return best;
    endfunction

    task automatic wr_key(input logic [59:0] k);
        @(negedge clk);
        key0_we = 1; key0_wdata = {4'b0, k[59:48], k[47:32]};
        key1_we = 1; key1_wdata = k[31:0];
        @(negedge clk);
        key0_we = 0; key1_we = 0;
    endtask

    task automatic wr_attr(input logic [31:0] w);
        @(negedge clk);
        attr_we = 1; attr_wdata = w;
        @(negedge clk);
        attr_we = 0;
    endtask

    task automatic run_cmd(input int code, input int idx, output int cyc);
        @(negedge clk);
        ctrl_we = 1; ctrl_shot = 1; ctrl_cmd = code[2:0]; ctrl_index = idx[IDX_W-1:0];
        @(negedge clk);
        ctrl_we = 0; ctrl_shot = 0;
        cyc = 1;
        while (shot_rd && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic learn(input logic [59:0] k, input logic [31:0] w);
        int c;
        wr_key(k); wr_attr(w); run_cmd(0, 0, c);
    endtask

    task automatic lookup(input logic [59:0] k);
        int c;
        wr_key(k); run_cmd(2, 0, c);
    endtask

    task automatic read_at(input int idx);
        int c;
        run_cmd(3, idx, c);
    endtask

    task automatic set_skip(input bit s);
        @(negedge clk);
        scan_we = 1; scan_skip_locked = s;
        @(negedge clk);
        scan_we = 0;
    endtask

    task automatic set_age(input logic [1:0] u, input int p);
        @(negedge clk);
        age_we = 1; age_unit = u; age_period = p[PER_W-1:0];
        @(negedge clk);
        age_we = 0;
    endtask

    task automatic walk(input bit skip, input string tag);
        logic [59:0] cur;
        int e, steps, expsteps, c;
        set_skip(skip);
        wr_key('0);
        cur = '0; steps = 0; expsteps = 0;
        for (int i = 0; i < ENTRIES; i++) if (mval[i] && !(skip && mlock[i])) expsteps++;
        for (int s = 0; s < ENTRIES + 4; s++) begin
            run_cmd(6, 0, c);
            e = exp_next(cur, skip);
            if (e < 0) begin
                chk({tag, " end valid"}, 64'(attr_rd[16]), 64'd0);
                chk({tag, " end key kept"}, 64'(got_key()), 64'(cur));
                break;
            end
            chk({tag, " next key"}, 64'(got_key()), 64'(mkey[e]));
            chk({tag, " next locked"}, 64'(attr_rd[17]), 64'(mlock[e]));
            cur = mkey[e];
            steps++;
        end
        chk({tag, " step count"}, 64'(steps), 64'(expsteps));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int c;
        logic [59:0] kx, kw;
        logic [31:0] w;
        for (int i = 0; i < ENTRIES; i++) begin mval[i] = 0; mlock[i] = 0; mkey[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk("R1 shot", 64'(shot_rd), 0);
        chk("R1 full", 64'(full_rd), 0);
        chk("R1 key0", 64'(key0_rd), 0);
        chk("R1 attr", 64'(attr_rd), 0);
        lookup('0);
        chk("R1 empty lookup", 64'(attr_rd), 0);

        // R3 key layout
        @(negedge clk);
        key0_we = 1; key0_wdata = 32'h0005_AABB; key1_we = 1; key1_wdata = 32'hCCDD_EEFF;
        @(negedge clk);
        key0_we = 0; key1_we = 0;
        chk("R3 key0 readback", 64'(key0_rd), 64'h0005_AABB);
        chk("R3 key1 readback", 64'(key1_rd), 64'hCCDD_EEFF);
        kx = {12'd5, 48'hAABB_CCDD_EEFF};

        // R4 learn then lookup
        learn(kx, 32'h0000_1003);
        lookup(kx);
        chk("R4 lookup attr", 64'(attr_rd), 64'h0001_1003);
        read_at(0);
        chk("R3 read key", 64'(got_key()), 64'(kx));

        // R5 miss
        lookup({12'd5, 48'hAABB_CCDD_EE00});
        chk("R5 miss attr", 64'(attr_rd), 0);

        // R6 overwrite
        learn(kx, 32'h0000_3007);
        lookup(kx);
        chk("R6 overwritten", 64'(attr_rd), 64'h0001_3007);
        read_at(1);
        chk("R6 no duplicate", 64'(attr_rd[16]), 0);

        // R8 unlearn
        wr_key(kx); run_cmd(1, 0, c);
        lookup(kx);
        chk("R8 removed", 64'(attr_rd), 0);

        // fill the table
        for (int i = 0; i < ENTRIES; i++) begin
            mkey[i] = mk(i); mlock[i] = (i % 4 == 0); mval[i] = 1;
            learn(mkey[i], (mlock[i] ? 32'h0002_0000 : 32'h0) | 32'(i));
        end
        chk("R7 not full yet", 64'(full_rd), 0);
        kx = {12'd9, 48'h0300_0000_0000};
        learn(kx, 32'h1);
        chk("R7 full flag", 64'(full_rd), 1);
        lookup(kx);
        chk("R7 overflow key absent", 64'(attr_rd), 0);
        lookup(mkey[9]);
        chk("R7 old entry intact", 64'(attr_rd), 64'h0001_0009);
        chk("R7 full sticky", 64'(full_rd), 1);

        // R10 / R11 ordered walks
        walk(0, "R10");
        walk(1, "R11");
        set_skip(0);

        // R9 read and write at index
        read_at(5);
        chk("R9 read key", 64'(got_key()), 64'(mkey[5]));
        chk("R9 read attr", 64'(attr_rd), 64'h0001_0005);
        kw = {12'd7, 48'h0400_0000_0055};
        w = 32'h0001_203F;
        wr_key(kw); wr_attr(w); run_cmd(4, 5, c);
        lookup(kw);
        chk("R9 written hit", 64'(attr_rd), 64'(w));
        lookup(mkey[5]);
        chk("R9 old key gone", 64'(attr_rd), 0);
        mkey[5] = kw; mlock[5] = 0;
        wr_key(mkey[6]); wr_attr(32'h0001_0000); run_cmd(4, 7, c);
        read_at(7);
        chk("R9 duplicate write dropped", 64'(got_key()), 64'(mkey[7]));
        walk(0, "R10 after write");

        // R2 busy-ignore, R12 clear
        wr_key('0);
        @(negedge clk);
        ctrl_we = 1; ctrl_shot = 1; ctrl_cmd = 3'd7;
        @(negedge clk);
        ctrl_cmd = 3'd0; key0_we = 1; key0_wdata = 32'h0001_0000;
        attr_we = 1; attr_wdata = 32'h5;
        chk("R2 shot high", 64'(shot_rd), 1);
        @(negedge clk);
        ctrl_we = 0; ctrl_shot = 0; key0_we = 0; attr_we = 0;
        c = 2;
        while (shot_rd && c < 5000) begin @(negedge clk); c++; end
        chk("R12 clear length", 64'(c >= ENTRIES), 1);
        chk("R2 shot back low", 64'(shot_rd), 0);
        chk("R2 key write ignored", 64'(key0_rd), 0);
        chk("R7 full cleared", 64'(full_rd), 0);
        run_cmd(6, 0, c);
        chk("R12 empty after clear", 64'(attr_rd[16]), 0);
        for (int i = 0; i < ENTRIES; i++) mval[i] = 0;

        // R13 ageing
        learn(mk(1), 32'h0000_0001);
        learn(mk(2), 32'h0002_0002);
        run_cmd(5, 0, c);
        read_at(0); chk("R13 unlocked after one sweep", 64'(attr_rd[16]), 1);
        read_at(1); chk("R13 locked after one sweep", 64'(attr_rd[16]), 1);
        run_cmd(5, 0, c);
        read_at(0); chk("R13 unlocked aged out", 64'(attr_rd[16]), 0);
        read_at(1); chk("R13 locked kept", 64'(attr_rd[16]), 1);
        learn(mk(3), 32'h0000_0003);
        run_cmd(5, 0, c);
        lookup(mk(3));
        chk("R13 refresh hit", 64'(attr_rd), 64'h0001_0003);
        run_cmd(5, 0, c);
        read_at(0); chk("R13 refreshed survives", 64'(attr_rd[16]), 1);
        run_cmd(5, 0, c);
        read_at(0); chk("R13 refreshed then aged", 64'(attr_rd[16]), 0);

        // R14 background timer
        wr_key('0); run_cmd(7, 0, c);
        learn(mk(4), 32'h4);
        set_age(2'd0, 5);
        repeat (100) @(negedge clk);
        read_at(0); chk("R14 timed ageing", 64'(attr_rd[16]), 0);
        set_age(2'd0, 0);
        learn(mk(4), 32'h4);
        repeat (100) @(negedge clk);
        read_at(0); chk("R14 period zero disabled", 64'(attr_rd[16]), 1);
        set_age(2'd3, 1);
        repeat (100) @(negedge clk);
        read_at(0); chk("R14 slow unit not elapsed", 64'(attr_rd[16]), 1);
        set_age(2'd0, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule